// File: doc/BRIEF.md
# Relocatable Window Address-Map Registers

This block holds the two 64-bit configuration words that place, size and enable a memory-mapped storage window. Software reaches them through a small register port in which each word occupies an 8-byte slot. A write to a word is merged under a fixed per-word mask, so only the meaningful fields ever change. From the stored words the block derives the window base address, the window enable, the window size and the shift that sets the spacing between storage cells.

Whenever a write actually alters a stored word, the block raises a one-cycle reconfigure strobe in the cycle after the write. A write that leaves the word unchanged produces no strobe. The strobe is generated by a two-state machine. `ST_IDLE` is the quiet state. It moves to `ST_PULSE` on a changing write (transition IDLE_TO_PULSE) and otherwise stays idle (IDLE_HOLD). `ST_PULSE` drives the strobe. It stays in `ST_PULSE` when a further changing write arrives in that cycle (PULSE_RETRIGGER) and otherwise returns to `ST_IDLE` (PULSE_TO_IDLE).

The window size follows the size field only when the resulting size is a power of two; any other value leaves the previous size in place.

Top module: `itw_addrmap`

## Requirements
- R1: The word index is `addr_i[ADDR_W-1:3]`, and address bits 2:0 are ignored. `rdata_o` shows word 0 for index 0 and word 1 for index 1. For any index of 2 or more it reads 0.
- R2: A write to any index other than 0 or 1 leaves both words unchanged and raises no strobe.
- R3: A write to word 0 stores only the data bits under mask 0xFFFF_FC01, which are bits 31:10 (base) and bit 0 (enable). Every other bit of word 0 keeps its value, so those bits stay 0.
- R4: A write to word 1 stores only bits 16:10 (size field) and bits 2:0 (grain field). All other bits keep their value, including the cell count held at bit 20 upward.
- R5: `win_base_o` equals word 0 bits 31:0 ANDed with 0xFFFF_FC00. `win_en_o` equals word 0 bit 0.
- R6: `stride_shift_o` equals 7 plus word 1 bits 2:0, so it lies in the range 7 to 14.
- R7: The candidate size is 1024 plus (word 1 AND 0x1FC00). `win_size_o` takes the candidate in the same cycle as the stored word when the candidate is a power of two. Otherwise it keeps its previous value.
- R8: After reset, word 0 is 0 and word 1 is 0xC00 ORed with NUM_CELLS shifted left by 20 (0x200_0C00 by default). `win_size_o` is then 4096 and the strobe is low.
- R9: `reconfig_o` is high in exactly the cycle after a write that changed a stored word. It stays low after a write that stored an identical value.
- R10: Changing writes on consecutive cycles keep `reconfig_o` high for consecutive cycles (PULSE_RETRIGGER). The strobe falls one cycle after the last changing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | ADDR_W | Byte address; the index is bits ADDR_W-1:3 |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data of the addressed word (combinational) |
| win_base_o | output | 32 | Window base address |
| win_en_o | output | 1 | Window enable |
| win_size_o | output | SIZE_W | Window size in bytes |
| stride_shift_o | output | 4 | Log2 of the cell spacing |
| reconfig_o | output | 1 | One-cycle reconfigure strobe |

## Verification
A wrong merge leaves a corrupted stored word. That word shows on `rdata_o` as soon as its index is addressed, and it appears in base, enable or stride one cycle after the faulty write. A wrongly held or wrongly updated size appears on `win_size_o` in the cycle after the write. A state machine stuck in `ST_PULSE` or `ST_IDLE` shows as a strobe that lasts too long or never appears. A per-clock reference model catches both kinds of fault within one cycle. Directed writes cover identical rewrites, ignored indices, non-power-of-two sizes and back-to-back changes.

// File: rtl/itw_pkg.sv
package itw_pkg;
    localparam logic [63:0] R0_MASK    = 64'h0000_0000_FFFF_FC01;
    localparam logic [31:0] BASE_MASK  = 32'hFFFF_FC00;
    localparam logic [63:0] AM_MASK    = 64'h0000_0000_0001_FC00;
    localparam logic [63:0] GRAIN_MASK = 64'h0000_0000_0000_0007;
    localparam logic [63:0] R1_MASK    = AM_MASK | GRAIN_MASK;
    localparam int          CELLS_POS  = 20;
    localparam int          AM_LSB     = 10;
    localparam int          AM_W       = 7;
    localparam int          SIZE_BASE  = 1024;
    localparam int          STRIDE_MIN = 7;
    localparam int          SIZE_W     = $clog2(int'(AM_MASK) + SIZE_BASE) + 1;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } itw_state_e;

    function automatic logic is_pow2(input logic [SIZE_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/itw_regbank.sv
module itw_regbank
    import itw_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_CELLS = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [63:0]       wdata_i,
    output logic [63:0]       reg0_q_o,
    output logic [63:0]       reg1_q_o,
    output logic [AM_W-1:0]   am_nxt_o,
    output logic              changed_o,
    output logic [63:0]       rdata_o
);
    localparam int NUM_REGS = 2;
    localparam int IDX_W    = ADDR_W - 3;
    localparam logic [63:0] R1_RST = (64'hFFF & AM_MASK) | (64'(NUM_CELLS) << CELLS_POS);

    logic [IDX_W-1:0]    idx;
    logic [63:0]         regs_q   [NUM_REGS];
    logic [63:0]         regs_nxt [NUM_REGS];
    logic [NUM_REGS-1:0] chg;

    assign idx = addr_i[ADDR_W-1:3];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [63:0] MSK = (g == 0) ? R0_MASK : R1_MASK;
        localparam logic [63:0] RST = (g == 0) ? 64'h0 : R1_RST;
        logic [63:0] q;
        logic [63:0] merged;
        logic        hit;

        assign hit    = wr_en_i && (idx == IDX_W'(g));
        assign merged = (wdata_i & MSK) | (q & ~MSK);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                q <= RST;
            end else if (hit) begin
                q <= merged;
            end
        end

        assign chg[g]      = hit && (merged != q);
        assign regs_nxt[g] = hit ? merged : q;
        assign regs_q[g]   = q;
    end

    assign reg0_q_o  = regs_q[0];
    assign reg1_q_o  = regs_q[1];
    assign am_nxt_o  = regs_nxt[1][AM_LSB +: AM_W];
    assign changed_o = |chg;

    always_comb begin
        if (idx == IDX_W'(0)) begin
            rdata_o = regs_q[0];
        end else if (idx == IDX_W'(1)) begin
            rdata_o = regs_q[1];
        end else begin
            rdata_o = 64'h0;
        end
    end

    assert_r0_spare_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg0_q_o & ~R0_MASK) == 64'h0);

    assert_ignored_index_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (idx >= IDX_W'(NUM_REGS))) |=> ($stable(reg0_q_o) && $stable(reg1_q_o)));

    assert_cells_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(reg1_q_o[63:17]) && $stable(reg1_q_o[9:3]));
endmodule

// File: rtl/itw_size.sv
module itw_size
    import itw_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              upd_i,
    input  logic [AM_W-1:0]   am_nxt_i,
    output logic [SIZE_W-1:0] size_o
);
    localparam logic [SIZE_W-1:0] SIZE_RST = SIZE_W'(4096);

    logic [SIZE_W-1:0] cand;

    assign cand = SIZE_W'(SIZE_BASE) + (SIZE_W'(am_nxt_i) << AM_LSB);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            size_o <= SIZE_RST;
        end else if (upd_i && is_pow2(cand)) begin
            size_o <= cand;
        end
    end

    assert_size_pow2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(size_o) == 1);
endmodule

// File: rtl/itw_pulse_fsm.sv
module itw_pulse_fsm
    import itw_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic changed_i,
    output logic reconfig_o
);
    itw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = changed_i ? ST_PULSE : ST_IDLE;
            ST_PULSE: state_d = changed_i ? ST_PULSE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reconfig_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  reconfig_o = 1'b0;
            ST_PULSE: reconfig_o = 1'b1;
            default:  reconfig_o = 1'b0;
        endcase
    end

    assert_pulse_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reconfig_o && !changed_i) |=> !reconfig_o);
endmodule

// File: rtl/itw_addrmap.sv
module itw_addrmap
    import itw_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_CELLS = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [63:0]       wdata_i,
    output logic [63:0]       rdata_o,
    output logic [31:0]       win_base_o,
    output logic              win_en_o,
    output logic [SIZE_W-1:0] win_size_o,
    output logic [3:0]        stride_shift_o,
    output logic              reconfig_o
);
    logic [63:0]     reg0_q;
    logic [63:0]     reg1_q;
    logic [AM_W-1:0] am_nxt;
    logic            changed;

    itw_regbank #(.ADDR_W(ADDR_W), .NUM_CELLS(NUM_CELLS)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .reg0_q_o (reg0_q),
        .reg1_q_o (reg1_q),
        .am_nxt_o (am_nxt),
        .changed_o(changed),
        .rdata_o  (rdata_o)
    );

    itw_size u_size (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .upd_i   (changed),
        .am_nxt_i(am_nxt),
        .size_o  (win_size_o)
    );

    itw_pulse_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .changed_i (changed),
        .reconfig_o(reconfig_o)
    );

    assign win_base_o     = reg0_q[31:0] & BASE_MASK;
    assign win_en_o       = reg0_q[0];
    assign stride_shift_o = 4'(STRIDE_MIN) + {1'b0, reg1_q[2:0]};

    assert_strobe_has_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reconfig_o |-> ((reg0_q != $past(reg0_q)) || (reg1_q != $past(reg1_q))));

    assert_change_strobes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((reg0_q != $past(reg0_q)) || (reg1_q != $past(reg1_q))) |-> reconfig_o);

    assert_stride_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stride_shift_o >= 4'd7) && (stride_shift_o <= 4'd14));
endmodule

// File: tb/itw_addrmap_tb.sv
module itw_addrmap_tb;
    localparam int ADDR_W    = 6;
    localparam int NUM_CELLS = 32;
    localparam int SIZE_W    = itw_pkg::SIZE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [63:0]       wdata = '0;
    logic [63:0]       rdata;
    logic [31:0]       win_base;
    logic              win_en;
    logic [SIZE_W-1:0] win_size;
    logic [3:0]        stride;
    logic              reconfig;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    itw_addrmap #(.ADDR_W(ADDR_W), .NUM_CELLS(NUM_CELLS)) u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .wr_en_i       (wr_en),
        .addr_i        (addr),
        .wdata_i       (wdata),
        .rdata_o       (rdata),
        .win_base_o    (win_base),
        .win_en_o      (win_en),
        .win_size_o    (win_size),
        .stride_shift_o(stride),
        .reconfig_o    (reconfig)
    );

    // behavioural reference model
    longint unsigned m_w0, m_w1, m_size;
    bit              m_rec;

    function automatic bit pow2(longint unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_w0   = 0;
            m_w1   = 64'hC00 | (longint'(NUM_CELLS) << 20);
            m_size = 4096;
            m_rec  = 0;
        end else begin
            longint unsigned nv;
            m_rec = 0;
            if (wr_en && (addr / 8) == 0) begin
                nv = (wdata & 64'hFFFF_FC01) | (m_w0 & ~64'hFFFF_FC01);
                if (nv != m_w0) m_rec = 1;
                m_w0 = nv;
            end else if (wr_en && (addr / 8) == 1) begin
                nv = (wdata & 64'h1FC07) | (m_w1 & ~64'h1FC07);
                if (nv != m_w1) m_rec = 1;
                m_w1 = nv;
            end
            if (m_rec && pow2(1024 + (m_w1 & 64'h1FC00)))
                m_size = 1024 + (m_w1 & 64'h1FC00);
        end
    end

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            longint unsigned exp_rd;
            exp_rd = (addr / 8 == 0) ? m_w0 : (addr / 8 == 1) ? m_w1 : 0;
            check("R1 read data", rdata, exp_rd);
            check("R5 base", 64'(win_base), m_w0 & 64'hFFFF_FC00);
            check("R5 enable", 64'(win_en), m_w0 & 1);
            check("R6 stride", 64'(stride), 7 + (m_w1 & 7));
            check("R7 size", 64'(win_size), m_size);
            check("R9 strobe", 64'(reconfig), 64'(m_rec));
        end
    end

    task automatic wr(logic [ADDR_W-1:0] a, logic [63:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [ADDR_W-1:0] a, logic [63:0] exp);
        @(posedge clk); #2;
        addr = a;
        @(negedge clk);
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset size", 64'(win_size), 64'd4096);
        check("R8 reset strobe", 64'(reconfig), 64'd0);
        rd_chk("R8 reset word0", 6'd0, 64'h0);
        rd_chk("R8 reset word1", 6'd8, 64'h200_0C00);
        rd_chk("R1 index 2 reads 0", 6'd16, 64'h0);
        rd_chk("R1 low bits ignored", 6'd13, 64'h200_0C00);

        wr(6'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        check("R9 strobe after change", 64'(reconfig), 64'd1);
        check("R3 word0 merge", rdata, 64'hFFFF_FC01);
        @(negedge clk);
        check("R9 single cycle", 64'(reconfig), 64'd0);

        wr(6'd0, 64'h1234_0000_FFFF_FC01);
        @(negedge clk);
        check("R9 identical write no strobe", 64'(reconfig), 64'd0);

        wr(6'd16, 64'h0);
        @(negedge clk);
        check("R2 ignored index strobe", 64'(reconfig), 64'd0);
        rd_chk("R2 word0 intact", 6'd0, 64'hFFFF_FC01);
        rd_chk("R2 word1 intact", 6'd8, 64'h200_0C00);

        wr(6'd9, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        check("R4 word1 merge", rdata, 64'h201_FC07);
        check("R7 size max", 64'(win_size), 64'h2_0000);
        check("R6 stride max", 64'(stride), 64'd14);

        wr(6'd8, 64'h800);
        @(negedge clk);
        check("R4 word1 field", rdata, 64'h200_0800);
        check("R7 non-pow2 holds", 64'(win_size), 64'h2_0000);
        check("R6 stride min", 64'(stride), 64'd7);

        // back-to-back changing writes
        @(posedge clk); #2;
        wr_en = 1'b1; addr = 6'd0; wdata = 64'h0;
        @(posedge clk); #2;
        addr = 6'd8; wdata = 64'h1C00;
        @(negedge clk);
        check("R10 first pulse", 64'(reconfig), 64'd1);
        @(posedge clk); #2;
        wr_en = 1'b0;
        @(negedge clk);
        check("R10 retrigger", 64'(reconfig), 64'd1);
        check("R7 size 8K", 64'(win_size), 64'h2000);
        @(negedge clk);
        check("R10 falls", 64'(reconfig), 64'd0);

        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #2;
            wr_en = ($urandom_range(0, 2) != 0);
            addr  = ADDR_W'($urandom_range(0, 23));
            wdata = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) wdata = 64'h0;
        end
        @(posedge clk); #2 wr_en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule